// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two double-precision IEEE-754 operands and reduces the outcome to a 4-bit one-hot condition code. The code replaces one selectable 4-bit field of a 32-bit condition register. It also lands in the condition-code bits of the floating-point status register, which is exposed here as the 5-bit slice at status bits 15:11.

Two compare modes are available. The unordered mode simply reports "unordered" whenever a NaN is involved. The ordered mode treats a NaN operand as an invalid operation. It raises a flag and abandons the command, so that neither register changes.

The destination is given as a 5-bit register number. Only multiples of four name a field. Any other value is an illegal command and is refused.

Top module: `fp_cmp_unit`

## Requirements
- R1: The condition code is one-hot: less-than is 4'b1000, greater-than is 4'b0100, equal is 4'b0010 and unordered is 4'b0001, comparing `op_a` against `op_b`.
- R2: An operand is a NaN when its 11 exponent bits (62:52) are all ones and its 52 fraction bits (51:0) are not all zero. In unordered mode (`cmd_ordered`=0), a NaN in either operand gives the code 4'b0001.
- R3: In ordered mode (`cmd_ordered`=1), a NaN in either operand pulses `invalid_op` with `done` and leaves `cond_reg` and `stat_cc` unchanged.
- R4: Positive zero and negative zero compare equal.
- R5: Non-NaN values are ordered by sign and magnitude. Every negative value is below every positive value. Among negatives, the larger magnitude is the smaller value. Infinities (exponent all ones, fraction zero) lie beyond every finite value, and two equal infinities compare equal.
- R6: For a legal command, the field index is `cmd_dest[4:2]`. Field k occupies `cond_reg` bits 31-4k down to 28-4k, so field 0 is the top nibble. The code replaces the whole field, and every other field keeps its value.
- R7: On a completed compare, `stat_cc[4]` (status bit 15) is cleared and `stat_cc[3:0]` (status bits 14:11) takes the code.
- R8: A command with `cmd_dest[1:0]` not zero pulses `illegal_cmd` with `done` and changes neither `cond_reg` nor `stat_cc`.
- R9: Reset clears `cond_reg`, `stat_cc`, `done`, `invalid_op` and `illegal_cmd`. Every command pulses `done` for exactly one cycle, in the cycle after `cmd_valid`, and the updated registers are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per compare |
| cmd_ordered | input | 1 | 1 = ordered compare, 0 = unordered compare |
| cmd_dest | input | 5 | Destination register number; bits 4:2 select the field |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_reg | output | 32 | Condition register, eight 4-bit fields |
| stat_cc | output | 5 | Status register bits 15:11 |
| done | output | 1 | Command completed (one-cycle pulse) |
| invalid_op | output | 1 | Ordered compare aborted on a NaN |
| illegal_cmd | output | 1 | Destination register number not a multiple of four |

## Verification
The checker assumes that `cmd_valid` is a single-cycle strobe, with operands, mode and destination stable in that cycle. It also assumes that no new command lands in the cycle where the previous result is judged. The bench drives each command for exactly one cycle at the falling edge and leaves a cycle between commands. The checker relates the registered result to the previous cycle's inputs, which depends on that spacing.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;

   typedef enum logic [3:0] {
      CC_NONE = 4'b0000,
      CC_UN   = 4'b0001,
      CC_EQ   = 4'b0010,
      CC_GT   = 4'b0100,
      CC_LT   = 4'b1000
   } cmp_code_e;

   // Operand class as seen by the ordering logic.
   typedef struct packed {
      logic sign;
      logic is_nan;
      logic is_zero;
   } op_class_t;

endpackage

// File: rtl/fp_cmp_classify.sv
module fp_cmp_classify
   import fp_cmp_pkg::*;
#(
   parameter int EXPW  = 11,
   parameter int FRACW = 52,
   localparam int OPW  = 1 + EXPW + FRACW,
   localparam int MAGW = EXPW + FRACW
) (
   input  logic [OPW-1:0]  operand,
   output op_class_t       cls,
   output logic [MAGW-1:0] mag
);

   logic [EXPW-1:0]  exp_f;
   logic [FRACW-1:0] frac_f;

   assign exp_f  = operand[OPW-2 -: EXPW];
   assign frac_f = operand[FRACW-1:0];
   assign mag    = operand[MAGW-1:0];

   always_comb begin
      cls.sign    = operand[OPW-1];
      cls.is_nan  = (&exp_f) && (|frac_f);
      cls.is_zero = ~(|mag);
   end

endmodule

// File: rtl/fp_cmp_order.sv
module fp_cmp_order
   import fp_cmp_pkg::*;
#(
   parameter int MAGW           = 63,
   parameter bit SIGNED_ZERO_EQ = 1'b1
) (
   input  op_class_t       cls_a,
   input  op_class_t       cls_b,
   input  logic [MAGW-1:0] mag_a,
   input  logic [MAGW-1:0] mag_b,
   output logic [3:0]      code
);

   logic zero_pair;

   generate
      if (SIGNED_ZERO_EQ) begin : g_zero_eq
         assign zero_pair = cls_a.is_zero & cls_b.is_zero;
      end else begin : g_zero_signed
         assign zero_pair = 1'b0;
      end
   endgenerate

   logic mag_lt;
   logic mag_eq;

   assign mag_lt = (mag_a < mag_b);
   assign mag_eq = (mag_a == mag_b);

   always_comb begin
      if (cls_a.is_nan | cls_b.is_nan) begin
         code = CC_UN;
      end else if (zero_pair) begin
         code = CC_EQ;
      end else if (cls_a.sign != cls_b.sign) begin
         code = cls_a.sign ? CC_LT : CC_GT;
      end else if (mag_eq) begin
         code = CC_EQ;
      end else if (mag_lt ^ cls_a.sign) begin
         code = CC_LT;
      end else begin
         code = CC_GT;
      end
   end

endmodule

// File: rtl/fp_cmp_field_ins.sv
module fp_cmp_field_ins #(
   parameter int NFLD = 8,
   parameter int FLDW = 4,
   localparam int IDXW = $clog2(NFLD),
   localparam int REGW = NFLD * FLDW
) (
   input  logic [REGW-1:0] reg_in,
   input  logic [IDXW-1:0] idx,
   input  logic [FLDW-1:0] value,
   output logic [REGW-1:0] reg_out
);

   // Field 0 sits at the most significant end of the register.
   for (genvar g = 0; g < NFLD; g++) begin : g_fld
      assign reg_out[(NFLD-1-g)*FLDW +: FLDW] =
         (idx == IDXW'(g)) ? value : reg_in[(NFLD-1-g)*FLDW +: FLDW];
   end

endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
   import fp_cmp_pkg::*;
#(
   parameter int EXPW           = 11,
   parameter int FRACW          = 52,
   parameter int NFLD           = 8,
   parameter int FLDW           = 4,
   parameter bit SIGNED_ZERO_EQ = 1'b1,
   localparam int OPW  = 1 + EXPW + FRACW,
   localparam int MAGW = EXPW + FRACW,
   localparam int IDXW = $clog2(NFLD),
   localparam int DSTW = IDXW + 2,
   localparam int REGW = NFLD * FLDW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic            cmd_ordered,
   input  logic [DSTW-1:0] cmd_dest,
   input  logic [OPW-1:0]  op_a,
   input  logic [OPW-1:0]  op_b,
   output logic [REGW-1:0] cond_reg,
   output logic [FLDW:0]   stat_cc,
   output logic            done,
   output logic            invalid_op,
   output logic            illegal_cmd
);

   if (FLDW != 4) begin : g_bad_fldw
      $error("fp_cmp_unit: FLDW must be 4 to hold the one-hot code");
   end
   if (EXPW < 2 || FRACW < 1) begin : g_bad_fmt
      $error("fp_cmp_unit: floating-point format too narrow");
   end
   if (NFLD < 2 || (1 << IDXW) != NFLD) begin : g_bad_nfld
      $error("fp_cmp_unit: NFLD must be a power of two, at least 2");
   end

   op_class_t       cls_a, cls_b;
   logic [MAGW-1:0] mag_a, mag_b;
   logic [3:0]      code;
   logic [REGW-1:0] cond_next;

   fp_cmp_classify #(.EXPW(EXPW), .FRACW(FRACW)) u_cls_a (
      .operand (op_a),
      .cls     (cls_a),
      .mag     (mag_a)
   );

   fp_cmp_classify #(.EXPW(EXPW), .FRACW(FRACW)) u_cls_b (
      .operand (op_b),
      .cls     (cls_b),
      .mag     (mag_b)
   );

   fp_cmp_order #(.MAGW(MAGW), .SIGNED_ZERO_EQ(SIGNED_ZERO_EQ)) u_order (
      .cls_a (cls_a),
      .cls_b (cls_b),
      .mag_a (mag_a),
      .mag_b (mag_b),
      .code  (code)
   );

   fp_cmp_field_ins #(.NFLD(NFLD), .FLDW(FLDW)) u_ins (
      .reg_in  (cond_reg),
      .idx     (cmd_dest[DSTW-1:2]),
      .value   (code),
      .reg_out (cond_next)
   );

   logic dest_ok;
   logic nan_trap;
   logic commit;

   assign dest_ok  = (cmd_dest[1:0] == 2'b00);
   assign nan_trap = cmd_ordered & (cls_a.is_nan | cls_b.is_nan);
   assign commit   = cmd_valid & dest_ok & ~nan_trap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_reg    <= '0;
         stat_cc     <= '0;
         done        <= 1'b0;
         invalid_op  <= 1'b0;
         illegal_cmd <= 1'b0;
      end else begin
         done        <= cmd_valid;
         illegal_cmd <= cmd_valid & ~dest_ok;
         invalid_op  <= cmd_valid & dest_ok & nan_trap;
         if (commit) begin
            cond_reg <= cond_next;
            stat_cc  <= {1'b0, code};
         end
      end
   end

endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk #(
   parameter int EXPW = 11,
   parameter int FRACW = 52,
   parameter int NFLD = 8,
   parameter int FLDW = 4,
   localparam int OPW  = 1 + EXPW + FRACW,
   localparam int IDXW = $clog2(NFLD),
   localparam int DSTW = IDXW + 2,
   localparam int REGW = NFLD * FLDW
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic            cmd_ordered,
   input logic [DSTW-1:0] cmd_dest,
   input logic [OPW-1:0]  op_a,
   input logic [OPW-1:0]  op_b,
   input logic [REGW-1:0] cond_reg,
   input logic [FLDW:0]   stat_cc,
   input logic            done,
   input logic            invalid_op,
   input logic            illegal_cmd
);

   logic a_nan, b_nan, any_nan, legal;
   assign a_nan   = (&op_a[OPW-2 -: EXPW]) && (|op_a[FRACW-1:0]);
   assign b_nan   = (&op_b[OPW-2 -: EXPW]) && (|op_b[FRACW-1:0]);
   assign any_nan = a_nan | b_nan;
   assign legal   = (cmd_dest[1:0] == 2'b00);

   // Mask of the field the last command targeted.
   logic [REGW-1:0] tgt_mask_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgt_mask_q <= '0;
      else        tgt_mask_q <= {{(REGW-FLDW){1'b0}}, {FLDW{1'b1}}}
                                << ((NFLD-1-int'(cmd_dest[DSTW-1:2])) * FLDW);
   end

   AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      done && !invalid_op && !illegal_cmd |-> $countones(stat_cc[3:0]) == 1); // R1

   AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ordered && legal && any_nan |=> stat_cc[3:0] == 4'b0001); // R2

   AST_ORDERED_NAN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ordered && legal && any_nan |=> invalid_op && $stable(cond_reg) && $stable(stat_cc)); // R3

   AST_OTHER_FIELDS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> ((cond_reg ^ $past(cond_reg)) & ~tgt_mask_q) == '0); // R6

   AST_STATUS_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      done && !invalid_op && !illegal_cmd |-> !stat_cc[FLDW]); // R7

   AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !legal |=> illegal_cmd && $stable(cond_reg) && $stable(stat_cc)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> done); // R9

   AST_DONE_ONLY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !done); // R9

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(invalid_op && illegal_cmd)); // R3

endmodule

bind fp_cmp_unit fp_cmp_unit_chk #(
   .EXPW(EXPW), .FRACW(FRACW), .NFLD(NFLD), .FLDW(FLDW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_ordered (cmd_ordered),
   .cmd_dest    (cmd_dest),
   .op_a        (op_a),
   .op_b        (op_b),
   .cond_reg    (cond_reg),
   .stat_cc     (stat_cc),
   .done        (done),
   .invalid_op  (invalid_op),
   .illegal_cmd (illegal_cmd)
);

// File: tb/fp_cmp_unit_bench.sv
module fp_cmp_unit_bench;

   localparam int NV = 13;

   // Operand encodings
   localparam logic [63:0] P1   = 64'h3FF0000000000000;
   localparam logic [63:0] P2   = 64'h4000000000000000;
   localparam logic [63:0] N1   = 64'hBFF0000000000000;
   localparam logic [63:0] N2   = 64'hC000000000000000;
   localparam logic [63:0] PZ   = 64'h0000000000000000;
   localparam logic [63:0] NZ   = 64'h8000000000000000;
   localparam logic [63:0] PINF = 64'h7FF0000000000000;
   localparam logic [63:0] NINF = 64'hFFF0000000000000;
   localparam logic [63:0] PMAX = 64'h7FEFFFFFFFFFFFFF;
   localparam logic [63:0] NMAX = 64'hFFEFFFFFFFFFFFFF;
   localparam logic [63:0] QNAN = 64'h7FF8000000000000;
   localparam logic [63:0] TNAN = 64'h7FF0000000000001;

   localparam logic [63:0] VA [NV] = '{P1, P2, P1, N1, N2, PZ, PINF, NINF, QNAN, P1, P1, NZ, PINF};
   localparam logic [63:0] VB [NV] = '{P2, P1, P1, N2, P1, NZ, PMAX, NMAX, P1, TNAN, P2, PZ, PINF};
   localparam logic        VM [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};
   localparam logic [4:0]  VD [NV] = '{0, 4, 8, 12, 16, 20, 24, 28, 0, 4, 8, 12, 16};
   localparam logic [3:0]  VC [NV] = '{8, 4, 2, 4, 8, 2, 4, 8, 1, 1, 8, 2, 2};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ordered = 1'b0;
   logic [4:0]  cmd_dest = '0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic [31:0] cond_reg;
   logic [4:0]  stat_cc;
   logic        done, invalid_op, illegal_cmd;

   int errors = 0;
   int checks = 0;
   logic [31:0] cr_model = '0;
   logic [4:0]  cc_model = '0;

   always #4 clk = ~clk;

   fp_cmp_unit u_fp_cmp_unit (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ordered(cmd_ordered),
      .cmd_dest(cmd_dest), .op_a(op_a), .op_b(op_b), .cond_reg(cond_reg),
      .stat_cc(stat_cc), .done(done), .invalid_op(invalid_op), .illegal_cmd(illegal_cmd)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   // Drive one command at a falling edge; return at the falling edge after it.
   task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic ordm, input logic [4:0] dst);
      op_a = a; op_b = b; cmd_ordered = ordm; cmd_dest = dst; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   initial begin
      #(8 * 5000);
      errors++;
      $display("FAIL R9 watchdog actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(cond_reg == 32'h0, "R9 reset cond_reg", cond_reg, 0);
      chk(stat_cc == 5'h0, "R9 reset stat_cc", stat_cc, 0);
      chk(!done && !invalid_op && !illegal_cmd, "R9 reset flags",
          {done, invalid_op, illegal_cmd}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R1 R2 R4 R5 R6 R7 R9
      for (int i = 0; i < NV; i++) begin
         issue(VA[i], VB[i], VM[i], VD[i]);
         cr_model[31 - 4*int'(VD[i][4:2]) -: 4] = VC[i];
         cc_model = {1'b0, VC[i]};
         chk(done, "R9 done pulse", done, 1);
         chk(stat_cc[3:0] == VC[i], "R1 code", stat_cc[3:0], VC[i]);
         chk(stat_cc == cc_model, "R7 status slice", stat_cc, cc_model);
         chk(cond_reg == cr_model, "R6 cond_reg field", cond_reg, cr_model);
         chk(!invalid_op && !illegal_cmd, "R3 no flags", {invalid_op, illegal_cmd}, 0);
         @(negedge clk);
         chk(!done, "R9 done one cycle", done, 0);
      end

      // R2: NaN in second operand, unordered mode, field 7
      issue(N1, QNAN, 1'b0, 5'd28);
      cr_model[3:0] = 4'h1; cc_model = 5'h01;
      chk(stat_cc == 5'h01 && cond_reg == cr_model, "R2 nan b unordered", cond_reg, cr_model);
      @(negedge clk);

      // R3: ordered mode NaN aborts
      issue(QNAN, P1, 1'b1, 5'd0);
      chk(invalid_op && done, "R3 invalid pulse", {done, invalid_op}, 2'b11);
      chk(cond_reg == cr_model, "R3 cond_reg held", cond_reg, cr_model);
      chk(stat_cc == cc_model, "R3 stat_cc held", stat_cc, cc_model);
      @(negedge clk);
      chk(!invalid_op, "R3 invalid one cycle", invalid_op, 0);

      // R8: illegal destination numbers
      for (int d = 1; d < 4; d++) begin
         issue(P2, P1, 1'b0, 5'(d + 8));
         chk(illegal_cmd && done && !invalid_op, "R8 illegal pulse", {done, illegal_cmd}, 2'b11);
         chk(cond_reg == cr_model && stat_cc == cc_model, "R8 no update", cond_reg, cr_model);
         @(negedge clk);
      end

      // R8: illegal destination with ordered NaN still reports illegal only
      issue(QNAN, QNAN, 1'b1, 5'd2);
      chk(illegal_cmd && !invalid_op, "R8 illegal over nan", {illegal_cmd, invalid_op}, 2'b10);
      @(negedge clk);

      // R5: negative infinity below positive zero, field 2
      issue(NINF, PZ, 1'b1, 5'd8);
      cr_model[23:20] = 4'h8; cc_model = 5'h08;
      chk(cond_reg == cr_model && stat_cc == cc_model, "R5 -inf < +0", cond_reg, cr_model);
      @(negedge clk);

      // R9: reset clears again
      rst_n = 1'b0;
      @(negedge clk);
      chk(cond_reg == 32'h0 && stat_cc == 5'h0, "R9 reset clears", cond_reg, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule